// File: doc/BRIEF.md
# Serial-Acknowledge Interrupt Chain

This block models a row of device interface slices that raise interrupts on one shared request line. Each slice keeps a pending flag, an enable flip-flop and a fixed vector code. The shared request line is high whenever at least one slice has an enabled pending flag. When the processor answers with an acknowledge pulse, the pulse enters slice 0 and travels along the row. The first slice that has an enabled pending request keeps the pulse. It puts its vector code on the shared vector bus and drops its pending flag. Every other slice hands the pulse to the next slice. Priority therefore comes only from position in the row: slice 0 is the highest.

Device events reach the block as one-cycle raise pulses, one bit per slice. Software reads and writes each slice's two status bits through a small status port, which selects a slice by index. The acknowledge path is combinational, so the vector appears in the same cycle as the acknowledge, and the pending flag clears at the following clock edge. The vector bus has no handshake: it is valid only in a cycle where the acknowledge is high and some slice has taken it.

Top module: `irq_ack_chain`

## Requirements
- R1: After reset every slice has enable = 0 and pending = 0, `irq_o` is 0 and `vec_o` is 0.
- R2: `irq_o` is 1 exactly when at least one slice has both enable and pending set.
- R3: A slice whose enable is 0 keeps its pending flag. It does not contribute to `irq_o` and always passes the acknowledge on.
- R4: While `ack_i` is 1, the lowest-index slice with enable and pending set takes the acknowledge in that same cycle. `vec_o` then shows that slice's code, which is VEC_BASE plus the slice index, modulo 2^VEC_W (8 + index by default).
- R5: At the clock edge that ends an acknowledge cycle, the pending flag of the slice that took it clears. All other slices keep their flags.
- R6: When no slice drives the bus, `vec_o` reads 0. `ack_pass_o` is 1 exactly when `ack_i` is 1 and no slice took the acknowledge.
- R7: No more than one bit of `drive_o` is ever 1. A bit is 1 only while that slice is driving the vector bus.
- R8: When `st_we_i` is 1, the selected slice loads `st_wdata_i` at the clock edge. Bit 0 is enable and bit 1 is pending. This write overrides a raise or an acknowledge clear on that slice in the same cycle.
- R9: A raise pulse sets the pending flag. It also wins over the clear of an acknowledge taken by the same slice in the same cycle.
- R10: `st_rdata_o` gives the status bits of slice `st_sel_i`, combinationally, with bit 0 = enable and bit 1 = pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raise_i | input | NUM_SLOTS | One-cycle request event per slice |
| ack_i | input | 1 | Acknowledge from the processor, enters slice 0 |
| st_sel_i | input | SEL_W | Slice index for status read and write |
| st_we_i | input | 1 | Status write strobe |
| st_wdata_i | input | 2 | Status write data: bit 0 enable, bit 1 pending |
| st_rdata_o | output | 2 | Status of the selected slice |
| irq_o | output | 1 | Shared request line |
| vec_o | output | VEC_W | Shared vector bus, 0 when undriven |
| drive_o | output | NUM_SLOTS | Which slice drives the vector bus |
| ack_pass_o | output | 1 | Acknowledge leaving the last slice unclaimed |

## Verification
The bench raises several slices at once and acknowledges repeatedly. A chain that inverted its order, or let two slices claim the pulse, would return the codes in the wrong order or drive more than one bit of `drive_o`. A disabled slice that holds a pending flag is then acknowledged. A design that ignored the enable would absorb the pulse and lose the flag, where a correct one passes the pulse through with the bus at zero. The bench also collides a raise and a status write with an acknowledge on the slice being served. A design with the wrong precedence would drop the new request or the written value.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
  localparam int ST_W = 2;

  typedef struct packed {
    logic pend;
    logic en;
  } slot_stat_t;
endpackage

// File: rtl/irq_slot.sv
module irq_slot
  import irq_chain_pkg::*;
#(
  parameter int VEC_W = 4,
  parameter logic [VEC_W-1:0] CODE = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack_in,
  output logic             ack_out,
  input  logic             raise,
  input  logic             wr_en,
  input  slot_stat_t       wr_data,
  output slot_stat_t       stat,
  output logic             req,
  output logic             drive,
  output logic [VEC_W-1:0] vec_drv
);
  slot_stat_t stat_q;

  assign req     = stat_q.en & stat_q.pend;
  assign drive   = ack_in & req;
  assign ack_out = ack_in & ~req;
  assign vec_drv = drive ? CODE : '0;
  assign stat    = stat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else if (wr_en) begin
      stat_q <= wr_data;
    end else begin
      stat_q.pend <= raise | (stat_q.pend & ~drive);
    end
  end

  // R5: a served slice drops its flag when nothing overrides it
  assert_served_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (drive && !wr_en && !raise) |=> !stat_q.pend);

  // R3: a masked slice never loses its flag and never claims the pulse
  assert_masked_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_q.en && !wr_en) |=> stat_q.pend >= $past(stat_q.pend));

  assert_masked_forwards_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_in && !stat_q.en) |-> ack_out);

  // R9: raise beats the acknowledge clear
  assert_raise_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (raise && !wr_en) |=> stat_q.pend);

  // R8: a status write lands as written
  assert_write_loads_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (stat_q == $past(wr_data)));
endmodule

// File: rtl/irq_vec_merge.sv
module irq_vec_merge #(
  parameter int N     = 4,
  parameter int VEC_W = 4
) (
  input  logic [N-1:0]            drive,
  input  logic [N-1:0][VEC_W-1:0] vec_drv,
  output logic [VEC_W-1:0]        vec
);
  always_comb begin
    vec = '0;
    for (int i = 0; i < N; i++) begin
      vec = vec | vec_drv[i];
    end
  end

  // R6: an idle bus reads zero
  always_comb begin
    if (drive == '0) assert_idle_zero_R6: assert (vec == '0);
  end
endmodule

// File: rtl/irq_ack_chain.sv
module irq_ack_chain
  import irq_chain_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int VEC_W     = 4,
  parameter int VEC_BASE  = 8,
  localparam int SEL_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] raise_i,
  input  logic                 ack_i,
  input  logic [SEL_W-1:0]     st_sel_i,
  input  logic                 st_we_i,
  input  logic [ST_W-1:0]      st_wdata_i,
  output logic [ST_W-1:0]      st_rdata_o,
  output logic                 irq_o,
  output logic [VEC_W-1:0]     vec_o,
  output logic [NUM_SLOTS-1:0] drive_o,
  output logic                 ack_pass_o
);
  logic [NUM_SLOTS:0]                ack_ch;
  logic [NUM_SLOTS-1:0]              req;
  logic [NUM_SLOTS-1:0]              drive;
  logic [NUM_SLOTS-1:0][VEC_W-1:0]   vec_drv;
  slot_stat_t [NUM_SLOTS-1:0]        stat;
  slot_stat_t                        wdata;

  assign ack_ch[0] = ack_i;
  assign wdata     = slot_stat_t'(st_wdata_i);

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    localparam logic [VEC_W-1:0] CODE_I = VEC_W'(VEC_BASE + i);
    logic wr_hit;
    assign wr_hit = st_we_i && (st_sel_i == SEL_W'(i));

    irq_slot #(.VEC_W(VEC_W), .CODE(CODE_I)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .ack_in  (ack_ch[i]),
      .ack_out (ack_ch[i+1]),
      .raise   (raise_i[i]),
      .wr_en   (wr_hit),
      .wr_data (wdata),
      .stat    (stat[i]),
      .req     (req[i]),
      .drive   (drive[i]),
      .vec_drv (vec_drv[i])
    );
  end

  irq_vec_merge #(.N(NUM_SLOTS), .VEC_W(VEC_W)) u_merge (
    .drive   (drive),
    .vec_drv (vec_drv),
    .vec     (vec_o)
  );

  assign irq_o      = |req;
  assign drive_o    = drive;
  assign ack_pass_o = ack_ch[NUM_SLOTS];
  assign st_rdata_o = stat[st_sel_i];

  // R7: at most one slice on the bus
  assert_one_driver_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(drive_o));

  // R6: an unclaimed pulse means no enabled request existed
  assert_pass_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_pass_o |-> !irq_o);

  // R4: a raised line with an acknowledge is always claimed
  assert_claimed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_o) |-> (drive_o != '0));

  // R1: state is clear in the first cycle after reset
  assert_reset_clear_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> !irq_o);
endmodule

// File: tb/sim_irq_ack_chain.sv
module sim_irq_ack_chain;
  localparam int K = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [K-1:0] raise_i = '0;
  logic         ack_i = 1'b0;
  logic [1:0]   st_sel_i = '0;
  logic         st_we_i = 1'b0;
  logic [1:0]   st_wdata_i = '0;
  logic [1:0]   st_rdata_o;
  logic         irq_o;
  logic [3:0]   vec_o;
  logic [K-1:0] drive_o;
  logic         ack_pass_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_ack_chain u0 (
    .clk(clk), .rst_n(rst_n), .raise_i(raise_i), .ack_i(ack_i),
    .st_sel_i(st_sel_i), .st_we_i(st_we_i), .st_wdata_i(st_wdata_i),
    .st_rdata_o(st_rdata_o), .irq_o(irq_o), .vec_o(vec_o),
    .drive_o(drive_o), .ack_pass_o(ack_pass_o)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    raise_i = '0; ack_i = 1'b0; st_we_i = 1'b0;
  endtask

  task automatic wr(int sel, logic en, logic pend);
    st_sel_i = 2'(sel); st_wdata_i = {pend, en}; st_we_i = 1'b1;
    step();
  endtask

  task automatic rd(string req, int sel, int exp);
    st_sel_i = 2'(sel);
    #1;
    chk(req, int'(st_rdata_o), exp);
  endtask

  task automatic drv_ok(string req);
    #1;
    chk(req, $countones(drive_o) <= 1, 1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 irq", int'(irq_o), 0);
    chk("R1 vec", int'(vec_o), 0);
    for (int i = 0; i < K; i++) rd("R1 status", i, 0);
  endtask

  task automatic t_priority_pair();
    for (int i = 0; i < K; i++) wr(i, 1'b1, 1'b0);
    #1; chk("R2 idle irq", int'(irq_o), 0);
    raise_i = 4'b0110;
    step();
    #1; chk("R2 irq raised", int'(irq_o), 1);
    ack_i = 1'b1;
    drv_ok("R7 pair");
    chk("R4 first code", int'(vec_o), 9);
    chk("R7 driver slot1", int'(drive_o), 2);
    chk("R6 no pass", int'(ack_pass_o), 0);
    step();
    rd("R5 slot1 cleared", 1, 1);
    rd("R5 slot2 kept", 2, 3);
    ack_i = 1'b1;
    #1; chk("R4 second code", int'(vec_o), 10);
    step();
    #1; chk("R2 irq dropped", int'(irq_o), 0);
    ack_i = 1'b1;
    #1;
    chk("R6 empty bus", int'(vec_o), 0);
    chk("R6 pass out", int'(ack_pass_o), 1);
    step();
  endtask

  task automatic t_masked();
    wr(0, 1'b0, 1'b1);
    #1; chk("R3 masked irq", int'(irq_o), 0);
    ack_i = 1'b1;
    #1;
    chk("R3 forwarded", int'(ack_pass_o), 1);
    chk("R3 bus idle", int'(vec_o), 0);
    drv_ok("R7 masked");
    step();
    rd("R3 pending kept", 0, 2);
    raise_i = 4'b1000;
    step();
    ack_i = 1'b1;
    #1; chk("R4 skip masked", int'(vec_o), 11);
    step();
    wr(0, 1'b1, 1'b1);
    #1; chk("R2 unmasked irq", int'(irq_o), 1);
    ack_i = 1'b1;
    #1; chk("R4 slot0 code", int'(vec_o), 8);
    step();
  endtask

  task automatic t_collide();
    raise_i = 4'b1000;
    step();
    ack_i = 1'b1; raise_i = 4'b1000;
    #1; chk("R4 slot3 served", int'(vec_o), 11);
    step();
    rd("R9 raise wins", 3, 3);
    ack_i = 1'b1;
    step();
    rd("R5 slot3 clear", 3, 1);
    raise_i = 4'b0010;
    step();
    ack_i = 1'b1; st_sel_i = 2'd1; st_wdata_i = 2'b11; st_we_i = 1'b1;
    #1; chk("R4 slot1 during write", int'(vec_o), 9);
    step();
    rd("R8 write overrides", 1, 3);
    wr(1, 1'b0, 1'b0);
    rd("R10 readback", 1, 0);
    rd("R10 other slot", 2, 1);
  endtask

  task automatic t_all_order();
    for (int i = 0; i < K; i++) wr(i, 1'b1, 1'b0);
    raise_i = 4'b1111;
    step();
    for (int i = 0; i < K; i++) begin
      ack_i = 1'b1;
      drv_ok("R7 full chain");
      chk("R4 order", int'(vec_o), 8 + i);
      chk("R7 onehot", int'(drive_o), 1 << i);
      step();
    end
    #1; chk("R2 all served", int'(irq_o), 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_priority_pair();
    t_masked();
    t_collide();
    t_all_order();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      repeat (5000) @(posedge clk);
    join_any
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule